// File: doc/BRIEF.md
# Transmit Phase-Align Buffer

This block moves 10-bit transmit characters from a selectable input clock into the internal character clock. The input clock and the character clock share one frequency but have an unknown phase relation. A small elastic store absorbs that phase offset, and also any slow drift of up to half a character period. A configuration bit picks the input clock: either the external transmit clock or the reference clock. Holding the re-center control low resets both pointers to a fixed distance apart.

One status output, `tx_err`, merges several conditions. The first is a sticky buffer fault, raised on overflow or underflow and held until the next re-center. The second is a one-cycle progress pulse from a free-running self-test character counter while self-test is on. The third is a powered-down transmit PLL, inferred when both output enables are low. The fourth is the absence of reference clock edges.

Top module: `txpa_align_buf`

## Requirements
- R1: With `clk_sel`=0 and both clocks running, `tx_din` is captured on each rising edge of the selected input clock. After the re-center settling time, every character leaves on `tx_dout`, one per `chr_clk` cycle, in the order it arrived, with none dropped or repeated.
- R2: `clk_sel`=1 makes `ref_clk` the capture clock. Characters then stream correctly even when `ext_clk` is stopped. `clk_sel`=0 makes `ext_clk` the capture clock.
- R3: An overflow (the writer catches the reader) or an underflow (the reader finds the store empty) drives `tx_err` high. `tx_err` stays high after the cause goes away.
- R4: While `recenter_n` is 0, the buffer fault is cleared and `tx_err` shows no buffer fault. After release, the pointers restart half the depth apart and data streams again without error.
- R5: After a re-center, a one-time shift of the input clock phase by plus or minus half a character period raises no error and loses no character.
- R6: While `bist_n` is 0, `tx_err` pulses high for exactly one `chr_clk` cycle every 511 cycles. Counting `chr_clk` rising edges from the first edge with `bist_n` low, the first pulse follows edge 511 and the next follows edge 1022.
- R7: While `bist_n` is 0, a standing buffer fault is hidden from `tx_err`. When `bist_n` returns to 1, the fault shows again.
- R8: `tx_err` is high whenever `oe_a` and `oe_b` are both 0. With either enable at 1, this condition adds nothing to `tx_err`.
- R9: If no `ref_clk` activity reaches the character domain for 16 `chr_clk` cycles, `tx_err` goes high. It is still low 8 cycles after the reference stops. It clears within a few cycles once edges return.
- R10: While `rst_n` is 0, with both enables at 1 and `bist_n` at 1, `tx_err` is 0 and `tx_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chr_clk | input | 1 | Internal transmit character clock (read side) |
| ext_clk | input | 1 | External transmit input clock |
| ref_clk | input | 1 | Reference clock; optional input clock, monitored for loss |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | Input clock select: 0 = ext_clk, 1 = ref_clk |
| recenter_n | input | 1 | Active-low re-center of the buffer pointers |
| bist_n | input | 1 | Active-low self-test enable |
| oe_a | input | 1 | Transmit output enable A |
| oe_b | input | 1 | Transmit output enable B |
| tx_din | input | 10 | Character input, in the selected input clock domain |
| tx_dout | output | 10 | Character output, in the chr_clk domain |
| tx_err | output | 1 | Combined error / self-test progress status |

## Verification
The streaming function is tried with three input patterns. The first is a phase-offset external clock. The second is the reference clock with the external clock stopped, which separates the two select values. The third is the external clock given one-time half-period phase steps in both directions, which separates tolerated drift from a real slip. Faults come from two patterns: a stopped input clock, which gives underflow, and a faster input clock, which gives overflow. Both confirm that the flag stays set until re-center. The self-test pattern runs with a fault already standing, so the pulse spacing and the masking are checked together. Stopping and then restarting the reference separates the loss timeout from normal operation.

// File: rtl/txpa_pkg.sv
package txpa_pkg;
  localparam int CHAR_W = 10;
  typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/txpa_rst_sync.sv
module txpa_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/txpa_sync.sv
module txpa_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/txpa_refmon.sv
module txpa_refmon #(
  parameter int LIMIT = 16
) (
  input  logic chr_clk,
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic chr_rst_n,
  output logic ref_lost
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          tgl_q, tgl_s, prev_q, lost_q, lost_d, seen;
  logic [CW-1:0] cnt_q, cnt_d;

  // reference-domain activity toggle
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= ~tgl_q;
  end

  txpa_sync #(.W(1), .RST_VAL(1'b0)) u_tgl_sync (
    .clk(chr_clk), .rst_n(chr_rst_n), .d(tgl_q), .q(tgl_s)
  );

  assign seen = tgl_s ^ prev_q;

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (seen) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (cnt_q == LAST) begin
      lost_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge chr_clk or negedge chr_rst_n) begin
    if (!chr_rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      prev_q <= tgl_s;
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign ref_lost = lost_q;

  // R9: loss is only declared after a full quiet window
  p_loss_window_r9: assert property (@(posedge chr_clk) disable iff (!chr_rst_n)
    $rose(lost_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/txpa_bist.sv
module txpa_bist #(
  parameter int LEN = 511
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pulse
);
  localparam int CW = $clog2(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    cnt_d   = '0;
    pulse_d = 1'b0;
    if (en) begin
      if (cnt_q == LAST) pulse_d = 1'b1;
      else               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R6: progress pulse is one cycle wide
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R6: pulse only at the end of a full pass
  p_pulse_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/txpa_align_buf.sv
module txpa_align_buf
  import txpa_pkg::*;
#(
  parameter int DEPTH          = 16,
  parameter int REF_LOSS_LIMIT = 16,
  parameter int BIST_LEN       = 511
) (
  input  logic  chr_clk,
  input  logic  ext_clk,
  input  logic  ref_clk,
  input  logic  rst_n,
  input  logic  clk_sel,
  input  logic  recenter_n,
  input  logic  bist_n,
  input  logic  oe_a,
  input  logic  oe_b,
  input  char_t tx_din,
  output char_t tx_dout,
  output logic  tx_err
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PW     = AW + 1;
  localparam int OFFSET = DEPTH / 2;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  localparam logic [PW-1:0] OFF_BIN  = PW'(OFFSET);
  localparam logic [PW-1:0] OFF_GRAY = OFF_BIN ^ (OFF_BIN >> 1);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic wclk, buf_arst_n, w_rst_n, r_rst_n, c_rst_n, f_rst_n;

  assign wclk       = clk_sel ? ref_clk : ext_clk;
  assign buf_arst_n = rst_n & recenter_n;

  txpa_rst_sync u_wrst (.clk(wclk),    .arst_n(buf_arst_n), .srst_n(w_rst_n));
  txpa_rst_sync u_rrst (.clk(chr_clk), .arst_n(buf_arst_n), .srst_n(r_rst_n));
  txpa_rst_sync u_crst (.clk(chr_clk), .arst_n(rst_n),      .srst_n(c_rst_n));
  txpa_rst_sync u_frst (.clk(ref_clk), .arst_n(rst_n),      .srst_n(f_rst_n));

  char_t mem [DEPTH];

  // ---------------- write side ----------------
  logic [PW-1:0] wr_bin_q, wr_bin_d, wr_gray_q, rd_gray_w, rd_bin_w, fill_w;
  logic          ovf_q, ovf_d;

  assign rd_bin_w = from_gray(rd_gray_w);
  assign fill_w   = wr_bin_q - rd_bin_w;

  always_comb begin
    wr_bin_d = wr_bin_q + 1'b1;
    ovf_d    = ovf_q | (fill_w == FULL_CNT);
  end

  always_ff @(posedge wclk or negedge w_rst_n) begin
    if (!w_rst_n) begin
      wr_bin_q  <= OFF_BIN;
      wr_gray_q <= OFF_GRAY;
      ovf_q     <= 1'b0;
    end else begin
      wr_bin_q  <= wr_bin_d;
      wr_gray_q <= to_gray(wr_bin_d);
      ovf_q     <= ovf_d;
    end
  end

  always_ff @(posedge wclk) begin
    mem[wr_bin_q[AW-1:0]] <= tx_din;
  end

  // ---------------- read side -----------------
  logic [PW-1:0] rd_bin_q, rd_bin_d, rd_gray_q, wr_gray_r, wr_bin_r;
  logic          unf_q, unf_d, ovf_c;
  char_t         dout_q, dout_d;

  assign wr_bin_r = from_gray(wr_gray_r);

  always_comb begin
    rd_bin_d = rd_bin_q + 1'b1;
    unf_d    = unf_q | (wr_bin_r == rd_bin_q);
    dout_d   = mem[rd_bin_q[AW-1:0]];
  end

  always_ff @(posedge chr_clk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
      unf_q     <= 1'b0;
      dout_q    <= '0;
    end else begin
      rd_bin_q  <= rd_bin_d;
      rd_gray_q <= to_gray(rd_bin_d);
      unf_q     <= unf_d;
      dout_q    <= dout_d;
    end
  end

  // ---------------- crossings -----------------
  txpa_sync #(.W(PW), .RST_VAL('0)) u_rd2w (
    .clk(wclk), .rst_n(w_rst_n), .d(rd_gray_q), .q(rd_gray_w)
  );
  txpa_sync #(.W(PW), .RST_VAL(OFF_GRAY)) u_wr2r (
    .clk(chr_clk), .rst_n(r_rst_n), .d(wr_gray_q), .q(wr_gray_r)
  );
  txpa_sync #(.W(1), .RST_VAL(1'b0)) u_ovf2r (
    .clk(chr_clk), .rst_n(r_rst_n), .d(ovf_q), .q(ovf_c)
  );

  // ---------------- status --------------------
  logic ref_lost, bist_pulse, pll_down, buf_fault, shown;

  txpa_refmon #(.LIMIT(REF_LOSS_LIMIT)) u_refmon (
    .chr_clk(chr_clk), .ref_clk(ref_clk), .ref_rst_n(f_rst_n),
    .chr_rst_n(c_rst_n), .ref_lost(ref_lost)
  );

  txpa_bist #(.LEN(BIST_LEN)) u_bist (
    .clk(chr_clk), .rst_n(c_rst_n), .en(~bist_n), .pulse(bist_pulse)
  );

  always_comb begin
    pll_down  = ~oe_a & ~oe_b;
    buf_fault = ovf_c | unf_q;
    shown     = bist_n ? buf_fault : bist_pulse;
    tx_err    = shown | pll_down | ref_lost;
  end

  assign tx_dout = dout_q;

  // R1: write pointer steps by exactly one per input clock
  p_wr_step_r1: assert property (@(posedge wclk) disable iff (!w_rst_n)
    $past(w_rst_n) |-> (wr_bin_q == PW'($past(wr_bin_q) + 1'b1)));
  // R3: underflow flag is sticky
  p_unf_hold_r3: assert property (@(posedge chr_clk) disable iff (!r_rst_n)
    unf_q |=> unf_q);
  // R3: overflow flag is sticky
  p_ovf_hold_r3: assert property (@(posedge wclk) disable iff (!w_rst_n)
    ovf_q |=> ovf_q);
  // R4: no buffer fault visible while re-centering
  p_recenter_clear_r4: assert property (@(posedge chr_clk) disable iff (!c_rst_n)
    (!recenter_n && bist_n && (oe_a || oe_b) && !ref_lost) |-> !tx_err);
  // R8: powered-down PLL forces the error
  p_pll_down_r8: assert property (@(posedge chr_clk) disable iff (!rst_n)
    (!oe_a && !oe_b) |-> tx_err);
  // R9: lost reference forces the error
  p_ref_lost_r9: assert property (@(posedge chr_clk) disable iff (!c_rst_n)
    ref_lost |-> tx_err);
endmodule

// File: tb/txpa_align_buf_tb.sv
`timescale 1ns/1ps
module txpa_align_buf_tb;
  import txpa_pkg::*;

  logic  chr_clk = 1'b0, ext_clk = 1'b0, ref_clk = 1'b0;
  logic  rst_n, clk_sel, recenter_n, bist_n, oe_a, oe_b;
  char_t tx_din, tx_dout, tx_cnt;
  logic  tx_err;
  logic  ext_run = 1'b1, ref_run = 1'b1;
  realtime ext_hi = 2.5, ext_lo = 2.5;
  int total = 0, bad = 0;

  txpa_align_buf u_dut (
    .chr_clk(chr_clk), .ext_clk(ext_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .clk_sel(clk_sel), .recenter_n(recenter_n), .bist_n(bist_n),
    .oe_a(oe_a), .oe_b(oe_b), .tx_din(tx_din), .tx_dout(tx_dout), .tx_err(tx_err)
  );

  always #2.5 chr_clk = ~chr_clk;   // 200 MHz

  initial begin
    #1;
    forever begin
      if (ref_run) begin ref_clk = 1'b1; #2.5; ref_clk = 1'b0; #2.5; end
      else #1;
    end
  end

  initial begin
    #3;
    forever begin
      if (ext_run) begin ext_clk = 1'b1; #(ext_hi); ext_clk = 1'b0; #(ext_lo); end
      else #1;
    end
  end

  // source characters, advanced on the falling edge of the selected clock
  wire src_clk = clk_sel ? ref_clk : ext_clk;
  initial tx_cnt = '0;
  always @(negedge src_clk) tx_cnt <= tx_cnt + 1'b1;
  assign tx_din = tx_cnt;

  // {clk_sel, oe_a, oe_b, expected tx_err}
  localparam logic [3:0] VEC [6] = '{4'b0110, 4'b1110, 4'b0001,
                                     4'b0100, 4'b1010, 4'b1001};

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge chr_clk);
  endtask

  task automatic recenter();
    @(negedge chr_clk) recenter_n = 1'b0;
    cycles(4);
    recenter_n = 1'b1;
    cycles(30);
  endtask

  task automatic stream(input int n, input string rq);
    char_t prev;
    int    errs;
    errs = 0;
    @(negedge chr_clk);
    prev = tx_dout;
    for (int i = 0; i < n; i++) begin
      @(negedge chr_clk);
      if (tx_dout != char_t'(prev + 1'b1)) errs++;
      prev = tx_dout;
    end
    check(errs == 0, rq, errs, 0);
  endtask

  initial begin
    #(200_000.0);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_sel = 1'b0; recenter_n = 1'b1; bist_n = 1'b1;
    oe_a = 1'b1; oe_b = 1'b1;
    cycles(6);
    check(tx_err == 1'b0, "R10 err in reset", tx_err, 0);
    check(tx_dout == '0, "R10 dout in reset", tx_dout, 0);
    rst_n = 1'b1;
    cycles(40);
    stream(40, "R1 ext clock stream");
    check(tx_err == 1'b0, "R1 no error", tx_err, 0);

    // table walk: clock select and output enables
    foreach (VEC[k]) begin
      @(negedge chr_clk);
      clk_sel = VEC[k][3]; oe_a = VEC[k][2]; oe_b = VEC[k][1];
      recenter();
      stream(40, VEC[k][3] ? "R2 ref clock stream" : "R1 ext clock stream");
      check(tx_err == VEC[k][0], "R8 enables vs error", tx_err, VEC[k][0]);
    end

    @(negedge chr_clk); clk_sel = 1'b0; oe_a = 1'b1; oe_b = 1'b1;
    recenter();

    // R5: +180 degree phase step
    @(posedge ext_clk) ext_lo = 5.0;
    @(posedge ext_clk) ext_lo = 2.5;
    stream(40, "R5 lag step stream");
    check(tx_err == 1'b0, "R5 lag step error", tx_err, 0);
    // R5: -180 degree step (two shortened low phases)
    @(posedge ext_clk) ext_lo = 1.25;
    @(posedge ext_clk);
    @(posedge ext_clk) ext_lo = 2.5;
    stream(40, "R5 lead step stream");
    check(tx_err == 1'b0, "R5 lead step error", tx_err, 0);

    // R2: reference clock used while external clock is stopped
    @(negedge chr_clk); clk_sel = 1'b1; ext_run = 1'b0;
    recenter();
    stream(40, "R2 ref with ext stopped");
    check(tx_err == 1'b0, "R2 no error", tx_err, 0);
    @(negedge chr_clk); ext_run = 1'b1; clk_sel = 1'b0;
    recenter();

    // R3: underflow by stopping the input clock
    ext_run = 1'b0;
    cycles(40);
    check(tx_err == 1'b1, "R3 underflow flagged", tx_err, 1);
    ext_run = 1'b1;
    cycles(20);
    check(tx_err == 1'b1, "R3 underflow sticky", tx_err, 1);

    // R6/R7: self-test pulses mask the standing fault
    begin
      int first, second, highs;
      first = 0; second = 0; highs = 0;
      @(negedge chr_clk) bist_n = 1'b0;
      for (int k = 1; k <= 1100; k++) begin
        @(negedge chr_clk);
        if (tx_err) begin
          highs++;
          if (first == 0) first = k;
          else if (second == 0) second = k;
        end
      end
      check(first == 511, "R6 first pulse", first, 511);
      check(second == 1022, "R6 second pulse", second, 1022);
      check(highs == 2, "R7 fault masked", highs, 2);
    end
    bist_n = 1'b1;
    cycles(2);
    check(tx_err == 1'b1, "R7 fault back after test", tx_err, 1);

    // R4: re-center clears the fault
    @(negedge chr_clk) recenter_n = 1'b0;
    cycles(3);
    check(tx_err == 1'b0, "R4 clear while low", tx_err, 1'b0);
    recenter_n = 1'b1;
    cycles(30);
    stream(40, "R4 stream after recenter");
    check(tx_err == 1'b0, "R4 no error after recenter", tx_err, 0);

    // R3: overflow with a fast input clock
    @(posedge ext_clk) begin ext_lo = 2.0; ext_hi = 2.0; end
    cycles(200);
    @(posedge ext_clk) begin ext_lo = 2.5; ext_hi = 2.5; end
    cycles(20);
    check(tx_err == 1'b1, "R3 overflow sticky", tx_err, 1);
    recenter();
    check(tx_err == 1'b0, "R4 overflow cleared", tx_err, 0);

    // R9: reference loss
    @(negedge chr_clk) ref_run = 1'b0;
    cycles(8);
    check(tx_err == 1'b0, "R9 not yet lost", tx_err, 0);
    cycles(22);
    check(tx_err == 1'b1, "R9 loss flagged", tx_err, 1);
    ref_run = 1'b1;
    cycles(10);
    check(tx_err == 1'b0, "R9 loss cleared", tx_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule